// File: doc/BRIEF.md
# Tri-Level PWM Command Decoder

This block turns a three-level PWM command into a clean two-level drive command plus a shutdown flag for a gate-drive sequencer. The analog front end supplies two digitised comparator flags: one says the input sits above the upper threshold, the other says it sits below the lower threshold. Threshold hysteresis lives inside those comparators. The decoder samples both flags on the system clock. It passes them through a synchroniser and sorts each sample into a HIGH, LOW or mid-band region.

A mid-band level means "switch both transistors off". It takes effect only after it has stayed there for a programmable number of clock cycles. Brief passes through the band while the controller swings between HIGH and LOW therefore leave the command unchanged. An undriven input floats into the mid band, so an open pin ends in shutdown. Leaving shutdown is immediate: the first valid HIGH or LOW sample sets the command, and a one-cycle marker reports the return to switching.

Top module: `tsd_pwm_decoder`

## Requirements
- R1: Flag encoding: `above_hi`=1 with `below_lo`=0 is HIGH; `below_lo`=1 with `above_hi`=0 is LOW. Both flags at 0 (open or mid-level input) and both flags at 1 (inconsistent comparators) are classified as the mid band.
- R2: A steady HIGH or LOW level applied just after a rising edge reaches `pwm_cmd` on the fourth rising edge that follows. The stages are two synchroniser flops, one classification register and one output register. Nothing shows on the first three edges.
- R3: When the mid band has been sampled on `HOLD_CYCLES` consecutive edges, `tristate_active` rises on the third edge after the last of those samples, and `pwm_cmd` is 0 for as long as `tristate_active` is 1.
- R4: A mid-band run of fewer than `HOLD_CYCLES` consecutive samples leaves `pwm_cmd` and `tristate_active` unchanged, so the last valid command is kept.
- R5: Leaving shutdown adds no delay. The first valid sample clears `tristate_active` and sets `pwm_cmd` to that level, with the same latency as R2 (LOW gives 0, HIGH gives 1).
- R6: `exit_pulse` is 1 for exactly one cycle, the cycle in which `tristate_active` falls, and is 0 at every other time.
- R7: Synchronous active-high reset gives `tristate_active`=1, `pwm_cmd`=0 and `exit_pulse`=0. Shutdown is then held until the first valid HIGH or LOW level arrives.
- R8: Any valid sample inside a mid-band run restarts the qualification count. Two mid runs of `HOLD_CYCLES`-1 samples each, separated by one valid sample, never cause shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| above_hi | input | 1 | Comparator flag: input above the upper threshold (asynchronous) |
| below_lo | input | 1 | Comparator flag: input below the lower threshold (asynchronous) |
| pwm_cmd | output | 1 | Registered two-level drive command, 1 = high-side on |
| tristate_active | output | 1 | Registered shutdown flag: both switches off |
| exit_pulse | output | 1 | One-cycle marker of the return from shutdown to switching |

## Verification
The bench targets the qualification boundary. A mid-band run one sample short of the hold-off must keep the previous command; a design that counts one cycle early would drop into shutdown there. A run of exactly the hold-off length must shut down on the predicted edge, and an off-by-one counter would miss it or fire late. A single valid sample between two near-full mid runs must restart the count; a counter that only pauses would shut down falsely. The bench also drives both flags high at once, which a design that trusts one flag would read as a valid level, and it times the exit marker against the release edge, where a level-sensitive or stretched marker would fail.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

  typedef enum logic [1:0] {
    RG_LOW  = 2'd0,
    RG_HIGH = 2'd1,
    RG_MID  = 2'd2
  } region_e;

  // flags: bit 1 = above upper threshold, bit 0 = below lower threshold
  function automatic region_e classify(input logic [1:0] flags);
    region_e r;
    case (flags)
      2'b10:   r = RG_HIGH;
      2'b01:   r = RG_LOW;
      default: r = RG_MID;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tsd_sync.sv
module tsd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/tsd_classify.sv
module tsd_classify
  import tsd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  flags_i,
  output region_e     region_o
);

  region_e region_q;

  always_ff @(posedge clk) begin
    if (rst) region_q <= RG_MID;
    else     region_q <= classify(flags_i);
  end

  assign region_o = region_q;

  p_high_decode_r1: assert property (@(posedge clk) disable iff (rst)
    (flags_i == 2'b10) |=> (region_q == RG_HIGH));

  p_conflict_mid_r1: assert property (@(posedge clk) disable iff (rst)
    (flags_i == 2'b11) |=> (region_q == RG_MID));

  p_open_mid_r1: assert property (@(posedge clk) disable iff (rst)
    (flags_i == 2'b00) |=> (region_q == RG_MID));

endmodule

// File: rtl/tsd_holdoff.sv
module tsd_holdoff
  import tsd_pkg::*;
#(
  parameter int HOLD_CYCLES = 18
) (
  input  logic    clk,
  input  logic    rst,
  input  region_e region_i,
  output logic    pwm_o,
  output logic    tri_o,
  output logic    exit_o
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_MAX = CNT_W'(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] HOLD_M1  = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pwm_q, tri_q, exit_q;
  logic             qualified;

  // the current mid sample completes the hold-off window
  assign qualified = (cnt_q >= HOLD_M1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pwm_q  <= 1'b0;
      tri_q  <= 1'b1;
      exit_q <= 1'b0;
    end else begin
      case (region_i)
        RG_HIGH, RG_LOW: begin
          cnt_q  <= '0;
          pwm_q  <= (region_i == RG_HIGH);
          tri_q  <= 1'b0;
          exit_q <= tri_q;
        end
        default: begin
          exit_q <= 1'b0;
          if (cnt_q != HOLD_MAX) cnt_q <= cnt_q + 1'b1;
          if (qualified) begin
            tri_q <= 1'b1;
            pwm_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign pwm_o  = pwm_q;
  assign tri_o  = tri_q;
  assign exit_o = exit_q;

  p_off_in_shutdown_r3: assert property (@(posedge clk) disable iff (rst)
    tri_q |-> !pwm_q);

  p_qualified_entry_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(tri_q) |-> ($past(cnt_q) == HOLD_M1));

  p_exit_on_release_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(tri_q) |-> exit_q);

  p_exit_single_r6: assert property (@(posedge clk) disable iff (rst)
    exit_q |=> !exit_q);

  p_count_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (region_i != RG_MID) |=> (cnt_q == '0));

endmodule

// File: rtl/tsd_pwm_decoder.sv
module tsd_pwm_decoder
  import tsd_pkg::*;
#(
  parameter int HOLD_CYCLES = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic above_hi,
  input  logic below_lo,
  output logic pwm_cmd,
  output logic tristate_active,
  output logic exit_pulse
);

  logic [1:0] flags_sync;
  region_e    region;

  tsd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({above_hi, below_lo}),
    .q_o (flags_sync)
  );

  tsd_classify u_cls (
    .clk      (clk),
    .rst      (rst),
    .flags_i  (flags_sync),
    .region_o (region)
  );

  tsd_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .region_i (region),
    .pwm_o    (pwm_cmd),
    .tri_o    (tristate_active),
    .exit_o   (exit_pulse)
  );

  p_exit_only_when_running_r6: assert property (@(posedge clk) disable iff (rst)
    exit_pulse |-> !tristate_active);

endmodule

// File: tb/sim_tsd_pwm_decoder.sv
module sim_tsd_pwm_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 18;
  localparam int LAT = 3;   // edges from first sync flop to output register input

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic above_hi = 1'b0;
  logic below_lo = 1'b0;
  logic pwm_cmd, tristate_active, exit_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  tsd_pwm_decoder #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .above_hi(above_hi), .below_lo(below_lo),
    .pwm_cmd(pwm_cmd), .tristate_active(tristate_active), .exit_pulse(exit_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // 0 = low, 1 = high, 2 = mid (R1)
  function automatic int region_of(input logic hi, input logic lo);
    if (hi && !lo) return 1;
    if (lo && !hi) return 0;
    return 2;
  endfunction

  // reference model built from the requirements
  int  pipe [LAT];
  int  m_cnt;
  bit  m_pwm, m_tri, m_exit;

  always @(posedge clk) begin
    int e;
    if (rst) begin
      for (int i = 0; i < LAT; i++) pipe[i] = 2;
      m_cnt = 0; m_pwm = 0; m_tri = 1; m_exit = 0;
    end else begin
      e = pipe[LAT-1];
      for (int i = LAT-1; i > 0; i--) pipe[i] = pipe[i-1];
      pipe[0] = region_of(above_hi, below_lo);
      if (e != 2) begin
        m_exit = m_tri;
        m_tri  = 0;
        m_pwm  = (e == 1);
        m_cnt  = 0;
      end else begin
        m_exit = 0;
        if (m_cnt + 1 >= HOLD) begin
          m_tri = 1;
          m_pwm = 0;
        end
        if (m_cnt < HOLD) m_cnt = m_cnt + 1;
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (pwm_cmd !== m_pwm) begin
        fails++;
        $display("FAIL R2 pwm_cmd actual=%b expected=%b at %0t", pwm_cmd, m_pwm, $time);
      end
      checks++;
      if (tristate_active !== m_tri) begin
        fails++;
        $display("FAIL R3 tristate_active actual=%b expected=%b at %0t", tristate_active, m_tri, $time);
      end
      checks++;
      if (exit_pulse !== m_exit) begin
        fails++;
        $display("FAIL R6 exit_pulse actual=%b expected=%b at %0t", exit_pulse, m_exit, $time);
      end
    end
  end

  task automatic expect_out(input string tag, input bit e_pwm, input bit e_tri, input bit e_exit);
    checks++;
    if (pwm_cmd !== e_pwm || tristate_active !== e_tri || exit_pulse !== e_exit) begin
      fails++;
      $display("FAIL %s actual pwm/tri/exit=%b%b%b expected=%b%b%b at %0t",
               tag, pwm_cmd, tristate_active, exit_pulse, e_pwm, e_tri, e_exit, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic hi, input logic lo);
    above_hi = hi;
    below_lo = lo;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1357_9bdf));
    drive(0, 0);
    step(3);
    expect_out("R7 in reset", 0, 1, 0);
    rst = 1'b0;
    step(1);
    expect_out("R7 after reset", 0, 1, 0);
    step(30);
    expect_out("R7 held while open", 0, 1, 0);

    // first valid HIGH: four edges of latency (R2, R5, R6)
    drive(1, 0);
    step(3);
    expect_out("R2 not yet visible", 0, 1, 0);
    step(1);
    expect_out("R5 exit to high", 1, 0, 1);
    step(1);
    expect_out("R6 pulse one cycle", 1, 0, 0);
    step(10);

    // short mid run keeps the command (R4)
    drive(0, 0);
    step(HOLD - 1);
    drive(1, 0);
    step(10);
    expect_out("R4 short mid ignored", 1, 0, 0);

    // inconsistent flags count as mid, exact hold-off boundary (R1, R3)
    drive(1, 1);
    step(HOLD + LAT - 1);
    expect_out("R3 one edge before shutdown", 1, 0, 0);
    step(1);
    expect_out("R1 R3 conflict flags shut down", 0, 1, 0);
    step(5);

    // exit to LOW (R5)
    drive(0, 1);
    step(4);
    expect_out("R5 exit to low", 0, 0, 1);
    step(5);

    // restart of count (R8)
    drive(0, 0); step(HOLD - 1);
    drive(0, 1); step(1);
    drive(0, 0); step(HOLD - 1);
    drive(0, 1); step(10);
    expect_out("R8 count restarted", 0, 0, 0);

    // open input for exactly HOLD samples, then HIGH
    drive(0, 0); step(HOLD);
    drive(1, 0); step(LAT);
    expect_out("R3 open input shutdown", 0, 1, 0);
    step(1);
    expect_out("R5 fast exit after boundary", 1, 0, 1);

    // constrained random segments
    for (int seg = 0; seg < 400; seg++) begin
      int f, len;
      f   = $urandom % 4;
      len = 1 + ($urandom % (2 * HOLD));
      if ((seg % 7) == 0) len = HOLD - 1 + ($urandom % 3);
      drive(f[1], f[0]);
      step(len);
    end
    drive(0, 1);
    step(10);
    expect_out("R2 final low", 0, 0, 0);

    finish_run();
  end

endmodule